// File: doc/BRIEF.md
# Control Endpoint Buffer Validation Logic

This block tracks whether the transmit (IN) buffer of each endpoint of a USB device holds a packet that is ready to send. Firmware makes a buffer ready with a validate command. The block then keeps a full flag for that endpoint and drives it to the packet transmitter as a ready indication. The flag stays set until the serial engine reports that the packet went out on the bus.

Endpoint 0 is the control pair, and its IN buffer is interlocked with its OUT buffer. The block keeps three flags for the control OUT side: an unread flag, an overwritten flag and a SETUP-pending flag. A validate of the control IN buffer is refused while the OUT side holds an overwrite condition or a SETUP that has not been serviced. An incoming SETUP cancels a control IN buffer that was already validated. A clear command on endpoint 0 marks the OUT contents as read.

Every validate command gets a one-cycle accept or reject pulse one clock after it is issued. All flags update at that same clock edge.

Top module: `ep_buf_guard`

## Requirements
- R1: A synchronous reset clears every IN full flag, the overwritten flag, the SETUP-pending flag and the unread state, and holds both result pulses low.
- R2: `cmd_op` = 0 means validate and 1 means clear. An accepted validate sets `in_full[cmd_ep]` at the next clock edge. Every validate gives exactly one result pulse, `val_ack` or `val_nak`, lasting one cycle and appearing in the cycle after the command. A clear command gives no result pulse.
- R3: `ev_in_sent` with endpoint `ev_in_ep` clears that endpoint's full flag. An accepted validate of the same endpoint in the same cycle wins, and the flag ends up set.
- R4: A validate of endpoint 0 is rejected while `ctl_ovr` is set. A rejected validate changes no flag.
- R5: A validate of endpoint 0 is rejected while `ctl_setup_pend` is set.
- R6: `ev_setup` clears `in_full[0]` and sets `ctl_setup_pend`. The full flags of the other endpoints are untouched.
- R7: When `ev_setup` and a validate of endpoint 0 occur in the same cycle, the validate is rejected and `in_full[0]` ends up clear.
- R8: `ctl_ovr` sets when a SETUP arrives while the control OUT buffer still holds unread contents from an earlier OUT or SETUP reception. It also sets on `ev_overwrite`. A SETUP into an empty control OUT buffer leaves it clear.
- R9: A clear command on endpoint 0 clears `ctl_ovr`, `ctl_setup_pend` and the unread state. A clear command on any other endpoint changes none of them.
- R10: A validate of an endpoint from 1 to NEP-1 is accepted whatever the state of the control interlock.
- R11: A validate whose `cmd_ep` is NEP or larger is rejected and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 1 | Command kind: 0 validate, 1 clear |
| cmd_ep | input | EPW | Target endpoint index |
| ev_in_sent | input | 1 | The serial engine finished sending an IN packet |
| ev_in_ep | input | EPW | Endpoint of the sent IN packet |
| ev_setup | input | 1 | A SETUP packet landed in the control OUT buffer |
| ev_out_rx | input | 1 | An OUT data packet landed in the control OUT buffer |
| ev_overwrite | input | 1 | The serial engine reports that the control OUT buffer was overwritten |
| in_full | output | NEP | Per-endpoint IN buffer full, which means ready to transmit |
| ctl_ovr | output | 1 | Control OUT overwritten flag |
| ctl_setup_pend | output | 1 | Unserviced SETUP in the control OUT buffer |
| val_ack | output | 1 | The validate from the previous cycle was accepted |
| val_nak | output | 1 | The validate from the previous cycle was rejected |

## Verification
The assertions check the cycle-level rules on every cycle:
- each validate gets exactly one result pulse, and a clear gets none;
- a validate of endpoint 0 is refused whenever an overwrite or a pending SETUP is visible;
- a SETUP always leaves the control IN buffer empty and the pending flag set;
- a sent packet empties its buffer unless the same endpoint is validated in the same cycle;
- endpoints other than 0 are never refused.

Some behaviour depends on history, and only the bench scenarios show it. An overwrite needs a second SETUP before a clear. A clear on another endpoint must leave the control state alone. A rejected validate must leave every flag as it was. An out-of-range endpoint must change nothing.

// File: rtl/ebg_pkg.sv
package ebg_pkg;

  localparam logic OP_VALIDATE = 1'b0;
  localparam logic OP_CLEAR    = 1'b1;

  // Next state of one IN full flag. Cancel beats set, and set beats tx done.
  function automatic logic full_next(logic cur, logic set, logic tx_done, logic cancel);
    if (cancel)  return 1'b0;
    if (set)     return 1'b1;
    if (tx_done) return 1'b0;
    return cur;
  endfunction

  // Endpoint 0 validate is refused while any of these holds.
  function automatic logic ctl_refuse(logic ovr, logic pend, logic setup_now);
    return ovr | pend | setup_now;
  endfunction

  // Overwrite: a SETUP arrives over unread contents that are not being read
  // in the same cycle, or the serial engine reports an overwrite directly.
  function automatic logic ovr_set(logic setup_now, logic unread, logic clr_now, logic ext_ovr);
    return ext_ovr | (setup_now & unread & ~clr_now);
  endfunction

endpackage

// File: rtl/ebg_cmd_decode.sv
module ebg_cmd_decode #(
  parameter int NEP = 5,
  parameter int EPW = 3
) (
  input  logic           cmd_valid,
  input  logic           cmd_op,
  input  logic [EPW-1:0] cmd_ep,
  input  logic           ev_in_sent,
  input  logic [EPW-1:0] ev_in_ep,
  output logic [NEP-1:0] val_hit,
  output logic [NEP-1:0] sent_hit,
  output logic           val_any,
  output logic           val_ep0,
  output logic           in_range,
  output logic           clr_ep0
);
  import ebg_pkg::*;

  localparam logic [EPW:0] NEP_W = NEP[EPW:0];

  logic is_val;
  logic is_clr;

  assign is_val   = cmd_valid & (cmd_op == OP_VALIDATE);
  assign is_clr   = cmd_valid & (cmd_op == OP_CLEAR);
  assign in_range = ({1'b0, cmd_ep} < NEP_W);
  assign val_any  = is_val;
  assign val_ep0  = is_val & (cmd_ep == '0);
  assign clr_ep0  = is_clr & (cmd_ep == '0);

  for (genvar i = 0; i < NEP; i++) begin : g_hit
    localparam logic [EPW-1:0] IDX = EPW'(i);
    assign val_hit[i]  = is_val & (cmd_ep == IDX);
    assign sent_hit[i] = ev_in_sent & (ev_in_ep == IDX);
  end

endmodule

// File: rtl/ebg_ctrl_lock.sv
module ebg_ctrl_lock (
  input  logic clk,
  input  logic rst,
  input  logic setup_i,
  input  logic out_rx_i,
  input  logic ovr_i,
  input  logic clr_i,
  output logic ovr_o,
  output logic pend_o,
  output logic refuse_o
);
  import ebg_pkg::*;

  logic unread_q;
  logic ovr_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unread_q <= 1'b0;
      ovr_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      unread_q <= setup_i | out_rx_i | (unread_q & ~clr_i);
      ovr_q    <= ovr_set(setup_i, unread_q, clr_i, ovr_i) | (ovr_q & ~clr_i);
      pend_q   <= setup_i | (pend_q & ~clr_i);
    end
  end

  assign ovr_o    = ovr_q;
  assign pend_o   = pend_q;
  assign refuse_o = ctl_refuse(ovr_q, pend_q, setup_i);

endmodule

// File: rtl/ebg_full_flag.sv
module ebg_full_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic tx_done_i,
  input  logic cancel_i,
  output logic full_o
);
  import ebg_pkg::*;

  logic full_q;

  always_ff @(posedge clk) begin
    if (rst) full_q <= 1'b0;
    else     full_q <= full_next(full_q, set_i, tx_done_i, cancel_i);
  end

  assign full_o = full_q;

endmodule

// File: rtl/ep_buf_guard.sv
module ep_buf_guard #(
  parameter int NEP = 5,
  parameter int EPW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic           cmd_op,
  input  logic [EPW-1:0] cmd_ep,
  input  logic           ev_in_sent,
  input  logic [EPW-1:0] ev_in_ep,
  input  logic           ev_setup,
  input  logic           ev_out_rx,
  input  logic           ev_overwrite,
  output logic [NEP-1:0] in_full,
  output logic           ctl_ovr,
  output logic           ctl_setup_pend,
  output logic           val_ack,
  output logic           val_nak
);

  // Named internal events, brought out for the checker.
  logic [NEP-1:0] val_hit;
  logic [NEP-1:0] sent_hit;
  logic           val_any;
  logic           val_ep0;
  logic           in_range;
  logic           clr_ep0;
  logic           ctl_refuse_now;
  logic           val_accept;
  logic           val_reject;
  logic           ack_q;
  logic           nak_q;

  ebg_cmd_decode #(.NEP(NEP), .EPW(EPW)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ep    (cmd_ep),
    .ev_in_sent(ev_in_sent),
    .ev_in_ep  (ev_in_ep),
    .val_hit   (val_hit),
    .sent_hit  (sent_hit),
    .val_any   (val_any),
    .val_ep0   (val_ep0),
    .in_range  (in_range),
    .clr_ep0   (clr_ep0)
  );

  ebg_ctrl_lock u_lock (
    .clk     (clk),
    .rst     (rst),
    .setup_i (ev_setup),
    .out_rx_i(ev_out_rx),
    .ovr_i   (ev_overwrite),
    .clr_i   (clr_ep0),
    .ovr_o   (ctl_ovr),
    .pend_o  (ctl_setup_pend),
    .refuse_o(ctl_refuse_now)
  );

  assign val_accept = val_any & in_range & ~(val_ep0 & ctl_refuse_now);
  assign val_reject = val_any & ~val_accept;

  for (genvar i = 0; i < NEP; i++) begin : g_ep
    logic cancel;
    if (i == 0) begin : g_ctl
      assign cancel = ev_setup;
    end else begin : g_plain
      assign cancel = 1'b0;
    end
    ebg_full_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .set_i    (val_hit[i] & val_accept),
      .tx_done_i(sent_hit[i]),
      .cancel_i (cancel),
      .full_o   (in_full[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      nak_q <= 1'b0;
    end else begin
      ack_q <= val_accept;
      nak_q <= val_reject;
    end
  end

  assign val_ack = ack_q;
  assign val_nak = nak_q;

endmodule

// File: rtl/ebg_checker.sv
module ebg_checker #(
  parameter int NEP = 5,
  parameter int EPW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           cmd_valid,
  input logic           cmd_op,
  input logic [EPW-1:0] cmd_ep,
  input logic           ev_in_sent,
  input logic [EPW-1:0] ev_in_ep,
  input logic           ev_setup,
  input logic [NEP-1:0] in_full,
  input logic           ctl_ovr,
  input logic           ctl_setup_pend,
  input logic           val_ack,
  input logic           val_nak
);

  localparam logic [EPW:0] NEP_W = NEP[EPW:0];

  logic is_val;
  assign is_val = cmd_valid & (cmd_op == 1'b0);

  // R1: state is clear in the cycle after reset.
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (in_full == '0 && !ctl_ovr && !ctl_setup_pend && !val_ack && !val_nak));

  // R2: one result pulse per validate.
  assert_one_result_R2: assert property (@(posedge clk) disable iff (rst)
    is_val |=> (val_ack ^ val_nak));

  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (rst)
    !is_val |=> !(val_ack || val_nak));

  // R4: an overwrite blocks the control IN validate.
  assert_ovr_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (is_val && cmd_ep == '0 && ctl_ovr) |=> val_nak);

  // R5: a pending SETUP blocks the control IN validate.
  assert_pend_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (is_val && cmd_ep == '0 && ctl_setup_pend) |=> val_nak);

  // R6: a SETUP empties the control IN buffer and marks a pending SETUP.
  assert_setup_cancels_R6: assert property (@(posedge clk) disable iff (rst)
    ev_setup |=> (!in_full[0] && ctl_setup_pend));

  // R7: a SETUP wins over a simultaneous control IN validate.
  assert_setup_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_setup && is_val && cmd_ep == '0) |=> val_nak);

  // R10: endpoints other than 0 that are in range are never refused.
  assert_plain_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (is_val && cmd_ep != '0 && {1'b0, cmd_ep} < NEP_W) |=> val_ack);

  // R11: an out-of-range endpoint is refused.
  assert_range_reject_R11: assert property (@(posedge clk) disable iff (rst)
    (is_val && {1'b0, cmd_ep} >= NEP_W) |=> val_nak);

  for (genvar i = 0; i < NEP; i++) begin : g_chk
    localparam logic [EPW-1:0] IDX = EPW'(i);
    // R3: a sent packet empties its buffer unless the same endpoint is revalidated.
    assert_tx_clears_R3: assert property (@(posedge clk) disable iff (rst)
      (ev_in_sent && ev_in_ep == IDX && !(is_val && cmd_ep == IDX)) |=> !in_full[i]);
    // R2: a full flag only rises after an accepted validate.
    assert_rise_needs_ack_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(in_full[i]) |-> val_ack);
  end

endmodule

bind ep_buf_guard ebg_checker #(.NEP(NEP), .EPW(EPW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .cmd_ep        (cmd_ep),
  .ev_in_sent    (ev_in_sent),
  .ev_in_ep      (ev_in_ep),
  .ev_setup      (ev_setup),
  .in_full       (in_full),
  .ctl_ovr       (ctl_ovr),
  .ctl_setup_pend(ctl_setup_pend),
  .val_ack       (val_ack),
  .val_nak       (val_nak)
);

// File: tb/ep_buf_guard_bench.sv
module ep_buf_guard_bench;

  localparam int NEP = 5;
  localparam int EPW = 3;

  logic           clk = 1'b0;
  logic           rst;
  logic           cmd_valid;
  logic           cmd_op;
  logic [EPW-1:0] cmd_ep;
  logic           ev_in_sent;
  logic [EPW-1:0] ev_in_ep;
  logic           ev_setup;
  logic           ev_out_rx;
  logic           ev_overwrite;
  logic [NEP-1:0] in_full;
  logic           ctl_ovr;
  logic           ctl_setup_pend;
  logic           val_ack;
  logic           val_nak;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic exp_q[$];   // expected result per validate: 1 accept, 0 reject
  string tag_q[$];

  always #2.5 clk = ~clk;

  ep_buf_guard #(.NEP(NEP), .EPW(EPW)) u_ep_buf_guard (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result pulse shows.
  always @(negedge clk) begin
    if (!rst && (val_ack || val_nak)) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected result", {30'd0, val_ack, val_nak}, 32'd0);
      end else begin
        automatic logic e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {30'd0, val_ack, val_nak}, e ? 32'd2 : 32'd1);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle();
    cmd_valid = 0; cmd_op = 0; cmd_ep = '0;
    ev_in_sent = 0; ev_in_ep = '0; ev_setup = 0; ev_out_rx = 0; ev_overwrite = 0;
  endtask

  // Let one clock edge pass and come back to the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic validate(input int ep, input logic exp_ok, input string tag);
    cmd_valid = 1; cmd_op = 1'b0; cmd_ep = EPW'(ep);
    exp_q.push_back(exp_ok);
    tag_q.push_back(tag);
  endtask

  task automatic clear_cmd(input int ep);
    cmd_valid = 1; cmd_op = 1'b1; cmd_ep = EPW'(ep);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 in_full", 32'(in_full), 0);
    chk("R1 ovr", 32'(ctl_ovr), 0);
    chk("R1 pend", 32'(ctl_setup_pend), 0);
    chk("R1 pulses", {30'd0, val_ack, val_nak}, 0);
    rst = 0;
    @(negedge clk);

    // R2: validate endpoint 2
    validate(2, 1, "R2 validate ep2"); tick();
    chk("R2 full set", 32'(in_full), 32'b00100);
    chk("R2 pulse one cycle", {30'd0, val_ack, val_nak}, 2);
    tick();
    chk("R2 pulse gone", {30'd0, val_ack, val_nak}, 0);
    clear_cmd(2); tick();
    chk("R2 clear gives no pulse", {30'd0, val_ack, val_nak}, 0);

    // R3: packet sent empties buffer
    ev_in_sent = 1; ev_in_ep = 3'd2; tick();
    chk("R3 sent clears", 32'(in_full), 0);
    validate(1, 1, "R3 validate with send"); ev_in_sent = 1; ev_in_ep = 3'd1; tick();
    chk("R3 validate wins", 32'(in_full), 32'b00010);
    ev_in_sent = 1; ev_in_ep = 3'd1; tick();
    chk("R3 sent clears ep1", 32'(in_full), 0);

    // R6: control IN validated, plain endpoint 3 validated, then SETUP
    validate(0, 1, "R6 validate ep0"); tick();
    validate(3, 1, "R6 validate ep3"); tick();
    chk("R6 before setup", 32'(in_full), 32'b01001);
    ev_setup = 1; tick();
    chk("R6 setup cancels ep0 only", 32'(in_full), 32'b01000);
    chk("R6 pend set", 32'(ctl_setup_pend), 1);
    chk("R8 first setup no ovr", 32'(ctl_ovr), 0);

    // R5: refused while SETUP pending
    validate(0, 0, "R5 nak on pend"); tick();
    chk("R5 flags unchanged", 32'(in_full), 32'b01000);

    // R8: second SETUP over unread contents
    ev_setup = 1; tick();
    chk("R8 ovr set", 32'(ctl_ovr), 1);

    // R9: clear on other endpoint has no effect, on endpoint 0 clears
    clear_cmd(3); tick();
    chk("R9 other clear ovr", 32'(ctl_ovr), 1);
    chk("R9 other clear pend", 32'(ctl_setup_pend), 1);
    chk("R9 other clear in_full", 32'(in_full), 32'b01000);
    clear_cmd(0); tick();
    chk("R9 ep0 clear ovr", 32'(ctl_ovr), 0);
    chk("R9 ep0 clear pend", 32'(ctl_setup_pend), 0);

    // R4: overwrite event blocks control validate; R10: others still accepted
    ev_overwrite = 1; tick();
    chk("R8 ext ovr", 32'(ctl_ovr), 1);
    validate(0, 0, "R4 nak on ovr"); tick();
    chk("R4 flags unchanged", 32'(in_full), 32'b01000);
    chk("R4 ovr kept", 32'(ctl_ovr), 1);
    validate(4, 1, "R10 ep4 accepted under ovr"); tick();
    chk("R10 full", 32'(in_full), 32'b11000);

    // R7: SETUP and control validate together
    clear_cmd(0); tick();
    validate(0, 1, "R7 pre validate"); tick();
    chk("R7 ep0 full", 32'(in_full[0]), 1);
    ev_setup = 1; validate(0, 0, "R7 setup wins"); tick();
    chk("R7 ep0 empty", 32'(in_full[0]), 0);
    chk("R7 pend", 32'(ctl_setup_pend), 1);
    chk("R8 setup into empty buffer", 32'(ctl_ovr), 0);

    // R11: out-of-range endpoint
    validate(6, 0, "R11 nak range"); tick();
    chk("R11 unchanged", 32'(in_full), 32'b11000);

    // R8: OUT data then SETUP before clear
    clear_cmd(0); tick();
    ev_out_rx = 1; tick();
    chk("R8 out alone no ovr", 32'(ctl_ovr), 0);
    ev_setup = 1; tick();
    chk("R8 setup over out data", 32'(ctl_ovr), 1);

    tick(); tick();
    chk("R2 scoreboard drained", 32'(exp_q.size()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule